// File: doc/BRIEF.md
# IrDA Receive Pulse Demodulator

This block is the receive front end between an infrared serial input pin and an ordinary UART receiver. In an infrared link a logic zero arrives as a short low pulse rather than a full bit-time low level. The demodulator samples the synchronized pin with a slow detection clock. It accepts a low pulse only when at least two consecutive detection samples see it. It then turns each accepted pulse into one low level on the UART receive line, lasting one bit time.

A free-running prescaler produces the detection clock as a one-cycle sample enable. A 3-bit select field picks a division of the peripheral clock by any power of two from 1 to 128. A mode bit routes either the demodulated signal or the raw pin to the UART line. Any write that changes the select field or the mode bit clears the pulse-detection state. This keeps reconfiguration from producing a false bit. The detection clock must stay faster than the UART bit clock, so the division period must be shorter than `BIT_CLKS`.

Top module: `irda_rx_demod`

## Requirements
- R1: The 8-bit control register stores the mode bit at bit 0 and the select field at bits 6:4. A read returns these fields, and bits 7 and 3:1 always read 0 whatever was written to them.
- R2: After reset the register reads 0x00, so the block is in bypass with select code 0.
- R3: Select code n sets the detection sample period to P = 2^n peripheral clocks. With mode 1, a low pulse lasting 2P clocks always produces an output bit, and a pulse lasting P clocks never does.
- R4: With code 0 and mode 1, a low pulse of one peripheral clock is discarded, and uart_rx_o stays high.
- R5: Each accepted pulse drives uart_rx_o low for exactly `BIT_CLKS` peripheral clocks, then high. A pulse that stays low much longer still produces only one low bit.
- R6: With mode 0, uart_rx_o equals rx_pin_i combinationally, including glitches shorter than one clock.
- R7: A register write that changes the select field or the mode bit forces the demodulated output high from the next clock edge and clears the low-sample count.
- R8: A register write that leaves both fields unchanged has no effect on a demodulated bit in progress.
- R9: With code 0 and mode 1, uart_rx_o falls on the fourth rising clock edge after rx_pin_i falls. This allows two synchronizer stages and two samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| rx_pin_i | input | 1 | Infrared receive pin, idle high |
| uart_rx_o | output | 1 | Receive line to the UART |

## Verification
A corrupted sample count shows up as a wrong accept or reject at the pulse-width boundary. Pulses of exactly P clocks and exactly 2P clocks show it within one pulse. A wrong prescaler tap moves that boundary, so it becomes visible at the first select code that is affected. A hold counter that loads a wrong value changes the length of the low bit, and a count of the low cycles shows it as soon as that bit ends. A detector that fails to clear on reconfiguration leaves the output low on the clock after the write, which is where the bench samples.

// File: rtl/irda_pkg.sv
package irda_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;  // prescaler width, taps up to /2^DIV_W
  localparam int unsigned REG_W = 8;
  localparam int unsigned SEL_LSB = 4;
  localparam int unsigned MODE_BIT = 0;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             mode;
  } irda_cfg_t;

  localparam irda_cfg_t CFG_RST = '{sel: '0, mode: 1'b0};
endpackage

// File: rtl/irda_ctrl_reg.sv
module irda_ctrl_reg
  import irda_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output irda_cfg_t        cfg_o,
  output logic             cfg_clr_o
);
  irda_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d.sel  = wdata_i[SEL_LSB +: SEL_W];
    cfg_d.mode = wdata_i[MODE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RST;
    else if (wr_i) cfg_q <= cfg_d;
  end

  // reconfiguration clears detector in the same edge the fields update
  assign cfg_clr_o = wr_i && (cfg_d != cfg_q);

  always_comb begin
    rdata_o                       = '0;
    rdata_o[SEL_LSB +: SEL_W]     = cfg_q.sel;
    rdata_o[MODE_BIT]             = cfg_q.mode;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/irda_prescaler.sv
module irda_prescaler
  import irda_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + DIV_W'(1);
  end

  // low sel bits all ones -> one tick every 2^sel clocks; sel 0 ticks always
  assign mask   = (DIV_W'(1) << sel_i) - DIV_W'(1);
  assign tick_o = (cnt_q & mask) == mask;
endmodule

// File: rtl/irda_sync.sv
module irda_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= 1'b1;
      else if (g == 0) st_q[g] <= d_i;
      else st_q[g] <= st_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/irda_pulse_det.sv
module irda_pulse_det #(
  parameter int unsigned BIT_CLKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_s_i,
  input  logic clr_i,
  output logic dem_o
);
  localparam int unsigned HOLD_W = $clog2(BIT_CLKS + 1);
  localparam logic [1:0]  CNT_SAT = 2'd2;

  logic [1:0]        lo_cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic              dem_q;
  logic              fire;

  // second consecutive low sample validates the pulse; saturation gives one bit per pulse
  assign fire = tick_i && !rx_s_i && (lo_cnt_q == 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 lo_cnt_q <= '0;
    else if (clr_i)              lo_cnt_q <= '0;
    else if (tick_i) begin
      if (rx_s_i)                lo_cnt_q <= '0;
      else if (lo_cnt_q != CNT_SAT) lo_cnt_q <= lo_cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      dem_q  <= 1'b1;
    end else if (clr_i) begin
      hold_q <= '0;
      dem_q  <= 1'b1;
    end else if (fire) begin
      hold_q <= HOLD_W'(BIT_CLKS - 1);
      dem_q  <= 1'b0;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - HOLD_W'(1);
    end else begin
      dem_q  <= 1'b1;
    end
  end

  assign dem_o = dem_q;
endmodule

// File: rtl/irda_rx_demod.sv
module irda_rx_demod
  import irda_pkg::*;
#(
  parameter int unsigned BIT_CLKS    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             rx_pin_i,
  output logic             uart_rx_o
);
  irda_cfg_t cfg_q;
  logic      cfg_clr;
  logic      tick;
  logic      rx_sync;
  logic      dem;

  irda_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .cfg_o     (cfg_q),
    .cfg_clr_o (cfg_clr)
  );

  irda_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (cfg_q.sel),
    .tick_o (tick)
  );

  irda_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_pin_i),
    .q_o    (rx_sync)
  );

  irda_pulse_det #(.BIT_CLKS(BIT_CLKS)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .rx_s_i (rx_sync),
    .clr_i  (cfg_clr),
    .dem_o  (dem)
  );

  assign uart_rx_o = cfg_q.mode ? dem : rx_pin_i;
endmodule

// File: rtl/irda_rx_demod_chk.sv
module irda_rx_demod_chk
  import irda_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             rx_pin_i,
  input logic             uart_rx_o,
  input logic             dem_i,
  input logic             sync_i,
  input irda_cfg_t        cfg_i
);
  localparam int unsigned RUN_W = $clog2(BIT_CLKS + 2) + 1;
  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_run <= '0;
    else if (!dem_i) low_run <= low_run + RUN_W'(1);
    else             low_run <= '0;
  end

  assert_wr_fields_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> (reg_rdata_o[MODE_BIT] == $past(reg_wdata_i[MODE_BIT])) &&
                 (reg_rdata_o[SEL_LSB +: SEL_W] == $past(reg_wdata_i[SEL_LSB +: SEL_W])));

  assert_two_samples_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dem_i) |-> !$past(sync_i));

  assert_low_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run <= RUN_W'(BIT_CLKS));

  assert_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.mode |-> (uart_rx_o == rx_pin_i));

  assert_cfg_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && ((reg_wdata_i[SEL_LSB +: SEL_W] != cfg_i.sel) ||
                  (reg_wdata_i[MODE_BIT] != cfg_i.mode))) |=> dem_i);
endmodule

bind irda_rx_demod irda_rx_demod_chk #(.BIT_CLKS(BIT_CLKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .rx_pin_i    (rx_pin_i),
  .uart_rx_o   (uart_rx_o),
  .dem_i       (dem),
  .sync_i      (rx_sync),
  .cfg_i       (cfg_q)
);

// File: tb/sim_irda_rx_demod.sv
`timescale 1ns/1ps
module sim_irda_rx_demod;
  localparam int unsigned BITC = 256;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       rx_pin_i = 1'b1;
  logic       uart_rx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  irda_rx_demod #(.BIT_CLKS(BITC)) u0 (
    .clk_i, .rst_ni, .reg_wr_i, .reg_wdata_i, .reg_rdata_o, .rx_pin_i, .uart_rx_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // low pulse of len clocks; counts output low cycles and falling edges over win clocks
  task automatic pulse(input int len, input int win, output int lows, output int falls);
    logic prev;
    lows = 0; falls = 0; prev = uart_rx_o;
    @(negedge clk_i);
    rx_pin_i = 1'b0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk_i);
      if (!uart_rx_o) lows++;
      if (prev && !uart_rx_o) falls++;
      prev = uart_rx_o;
      if (i == len - 1) rx_pin_i = 1'b1;
    end
  endtask

  task automatic t_reset;
    chk(reg_rdata_o == 8'h00, "R2 reset reg", reg_rdata_o, 0);
    rx_pin_i = 1'b0; #1;
    chk(uart_rx_o == 1'b0, "R2 bypass after reset", uart_rx_o, 0);
    rx_pin_i = 1'b1; #1;
    chk(uart_rx_o == 1'b1, "R2 bypass after reset", uart_rx_o, 1);
  endtask

  task automatic t_regs;
    wr_reg(8'hFF); #1;
    chk(reg_rdata_o == 8'h71, "R1 reserved bits read 0", reg_rdata_o, 8'h71);
    wr_reg(8'h8E); #1;
    chk(reg_rdata_o == 8'h00, "R1 reserved writes ignored", reg_rdata_o, 0);
    wr_reg(8'h50); #1;
    chk(reg_rdata_o == 8'h50, "R1 sel field", reg_rdata_o, 8'h50);
    wr_reg(8'h00);
  endtask

  task automatic t_bypass;
    wr_reg(8'h00);
    @(negedge clk_i);
    #2 rx_pin_i = 1'b0; #1;
    chk(uart_rx_o == 1'b0, "R6 glitch passes", uart_rx_o, 0);
    #1 rx_pin_i = 1'b1; #1;
    chk(uart_rx_o == 1'b1, "R6 glitch ends", uart_rx_o, 1);
  endtask

  task automatic t_glitch;
    int lows, falls;
    wr_reg(8'h01); idle(4);
    pulse(1, 20, lows, falls);
    chk(lows == 0, "R4 one-clock glitch rejected", lows, 0);
  endtask

  task automatic t_threshold;
    int lows, falls;
    for (int s = 0; s < 8; s++) begin
      int p = 1 << s;
      int win = 2 * p + p + BITC + 8;
      wr_reg(8'((s << 4) | 1)); idle(4);
      pulse(p, win, lows, falls);
      chk(lows == 0, $sformatf("R3 sel %0d pulse P rejected", s), lows, 0);
      idle(4);
      pulse(2 * p, win, lows, falls);
      chk(lows == BITC && falls == 1, $sformatf("R3 sel %0d pulse 2P accepted", s), lows, BITC);
      idle(4);
    end
  endtask

  task automatic t_long;
    int lows, falls;
    wr_reg(8'h00); wr_reg(8'h01); idle(4);
    pulse(3 * BITC, 4 * BITC, lows, falls);
    chk(falls == 1, "R5 one bit per long pulse", falls, 1);
    chk(lows == BITC, "R5 bit length", lows, BITC);
    idle(4);
  endtask

  task automatic t_latency;
    wr_reg(8'h01); idle(4);
    @(negedge clk_i); rx_pin_i = 1'b0;
    idle(3);
    chk(uart_rx_o == 1'b1, "R9 high after 3 edges", uart_rx_o, 1);
    idle(1);
    chk(uart_rx_o == 1'b0, "R9 low after 4 edges", uart_rx_o, 0);
    rx_pin_i = 1'b1;
    idle(BITC + 8);
  endtask

  task automatic t_reconfig;
    @(negedge clk_i); rx_pin_i = 1'b0;
    idle(2); rx_pin_i = 1'b1;
    idle(4);
    chk(uart_rx_o == 1'b0, "R8 bit in progress", uart_rx_o, 0);
    wr_reg(8'h01);
    chk(uart_rx_o == 1'b0, "R8 same-value write ignored", uart_rx_o, 0);
    wr_reg(8'h11);
    chk(uart_rx_o == 1'b1, "R7 sel change forces high", uart_rx_o, 1);
    idle(BITC + 8);
    chk(uart_rx_o == 1'b1, "R7 stays high", uart_rx_o, 1);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_bypass();
    t_glitch();
    t_latency();
    t_reconfig();
    t_long();
    t_threshold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule